// File: doc/BRIEF.md
# Zero-Skipping Block Coefficient Scanner

This block sits at the front of a residual entropy encoder for 4x4 video blocks. It accepts one block of sixteen signed coefficients in a single cycle. The coefficients are given in zig-zag order. In the same cycle it records which positions are nonzero, and it captures the block's nonzero count and its number of trailing unit-magnitude coefficients. The next stage uses these two values to pick its coefficient-token codeword.

A block with no nonzero coefficient does not enter the per-coefficient flow. In the next cycle it produces its whole codeword from a four-entry lookup, chosen by a context input. These zero-block codewords are joined MSB-first by a small bit packer, which emits a fixed-width word each time enough bits have built up. A block with nonzero content is walked from the highest zig-zag index down to index 0. A priority encoder on the remaining significance mask picks each step, so one nonzero coefficient is presented per cycle and zero positions take no cycles at all. With each coefficient the block gives its index, the number of zeros skipped before it, and a flag on the last one.

Top module: `coef_skip_scanner`

## Requirements
- R1: After reset, in_ready is 1 and out_valid, zb_valid and pk_valid are 0.
- R2: An accepted block whose sixteen coefficients are all zero raises zb_valid for exactly one cycle, the cycle after acceptance. It gives {zb_code, zb_len} by in_ctx: 0 gives "1" (len 1), 1 gives "11" (len 2), 2 gives "1111" (len 4), 3 gives "000011" (len 6). The code is right-aligned with zeros above the length. out_valid stays 0.
- R3: Coefficient i of a block is in_coefs[i*16 +: 16]. For a block with k nonzero coefficients, out_valid is high on exactly the k consecutive cycles that follow acceptance. On those cycles the nonzero positions come out in strictly descending index order, and zero positions use no cycle.
- R4: On each output cycle, out_coef equals the input coefficient value at out_idx.
- R5: out_run is the number of zero positions between this coefficient and the previously emitted one. For the first coefficient it counts from index 15 down.
- R6: out_last is 1 only on the final nonzero coefficient of a block.
- R7: out_total is the number of nonzero coefficients in the block and stays stable through its output cycles.
- R8: out_t1 counts the leading ±1 values among the nonzero coefficients, taken in descending index order. The count stops at the first nonzero value of other magnitude and saturates at 3.
- R9: in_ready is 0 from acceptance until the cycle after the last coefficient or after the zero-block codeword. in_valid and in_coefs presented while in_ready is 0 have no effect.
- R10: The zero-block codewords are joined MSB-first in the order they are emitted. Whenever 16 bits have built up, pk_valid pulses for one cycle, the cycle after the zb_valid that completed them. pk_word carries the oldest 16 bits, with the earliest bit in bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Block offered |
| in_ready | output | 1 | Block accepted when high with in_valid |
| in_coefs | input | 256 | Sixteen 16-bit coefficients, zig-zag index i at bits i*16 |
| in_ctx | input | 2 | Predicted-count context class for the zero-block codeword |
| out_valid | output | 1 | A nonzero coefficient is presented |
| out_coef | output | 16 | Coefficient value |
| out_idx | output | 4 | Zig-zag index of the coefficient |
| out_run | output | 4 | Zeros skipped before it in scan order |
| out_last | output | 1 | Final nonzero coefficient of the block |
| out_total | output | 5 | Nonzero count of the current block |
| out_t1 | output | 2 | Trailing ±1 count of the current block |
| zb_valid | output | 1 | Zero-block codeword valid |
| zb_code | output | 6 | Zero-block codeword, right-aligned |
| zb_len | output | 3 | Zero-block codeword length |
| pk_valid | output | 1 | Packed word valid |
| pk_word | output | 16 | Packed bits, earliest in MSB |

## Verification
All-zero blocks under each of the four contexts separate the bypass lookup from the scan path, and a long run of them drives the packer across many word boundaries. Blocks with a single nonzero at index 15 or index 0, and a fully dense block, test the priority walk, run lengths and last flag at both ends of the scan. Tails built from ±1 values, with a larger value placed after one, two, three or four of them, test the saturation and the stop of the trailing-ones count. Random sparse, dense and unit-heavy blocks are each sent with junk inputs held on in_valid while busy, which shows that a busy scanner ignores new offers.

// File: rtl/csc_pkg.sv
// Shared types and the zero-block codeword lookup for the coefficient scanner.
// Assumes a 2-bit context class selecting one of four codewords of up to 6 bits.
package csc_pkg;

    localparam int ZB_CODE_W = 6;
    localparam int ZB_LEN_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ZERO = 2'd1,
        ST_SCAN = 2'd2
    } scan_state_e;

    // Codeword bits for an empty block, right-aligned, zero above its length.
    function automatic logic [ZB_CODE_W-1:0] zb_code_f(input logic [1:0] ctx);
        case (ctx)
            2'd0:    return 6'b000001;
            2'd1:    return 6'b000011;
            2'd2:    return 6'b001111;
            default: return 6'b000011;
        endcase
    endfunction

    // Codeword length for an empty block.
    function automatic logic [ZB_LEN_W-1:0] zb_len_f(input logic [1:0] ctx);
        case (ctx)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/csc_load_stats.sv
// Load-time statistics of one block: significance mask, nonzero count and
// trailing unit-magnitude count (scan from the top index down, saturating at 3).
// Purely combinational; assumes coefficient i sits at bits [i*COEF_W +: COEF_W].
module csc_load_stats #(
    parameter int COEF_W = 16,
    parameter int NCOEF  = 16,
    parameter int CNT_W  = 5
) (
    input  logic [NCOEF*COEF_W-1:0] blk,
    output logic [NCOEF-1:0]        mask,
    output logic [CNT_W-1:0]        total,
    output logic [1:0]              t1
);

    logic [NCOEF-1:0] is_unit;

    // Per-position significance and unit-magnitude flags.
    for (genvar g = 0; g < NCOEF; g++) begin : g_flag
        assign mask[g]    = |blk[g*COEF_W +: COEF_W];
        assign is_unit[g] = (blk[g*COEF_W +: COEF_W] == COEF_W'(1)) ||
                            (blk[g*COEF_W +: COEF_W] == {COEF_W{1'b1}});
    end

    // Population count of the mask.
    always_comb begin
        total = '0;
        for (int i = 0; i < NCOEF; i++) begin
            total = total + CNT_W'(mask[i]);
        end
    end

    // Trailing-ones run in descending index order.
    always_comb begin
        logic stop;
        stop = 1'b0;
        t1   = 2'd0;
        for (int i = NCOEF - 1; i >= 0; i--) begin
            if (mask[i] && !stop) begin
                if (is_unit[i] && (t1 != 2'd3)) begin
                    t1 = t1 + 2'd1;
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/csc_prio_enc.sv
// Highest-set-bit priority encoder over the remaining significance mask.
// Assumes the caller qualifies the result; an empty request yields index 0.
module csc_prio_enc #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx
);

    // Later (higher) set bits override earlier ones.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/csc_bit_packer.sv
// MSB-first bit packer: appends variable-length codes and emits a PACK_W word
// the cycle after the push that completes it. Assumes code bits above len are
// zero and len <= CODE_W.
module csc_bit_packer #(
    parameter int PACK_W = 16,
    parameter int CODE_W = 6,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [CODE_W-1:0] code,
    input  logic [LEN_W-1:0]  len,
    output logic              word_valid,
    output logic [PACK_W-1:0] word
);

    localparam int ACC_W = PACK_W + CODE_W;
    localparam int CNT_W = $clog2(ACC_W + 1);

    logic [ACC_W-1:0] acc_q, acc_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             full;

    // Append the incoming code below the bits already held.
    always_comb begin
        acc_d = push ? ((acc_q << len) | ACC_W'(code)) : acc_q;
        cnt_d = push ? (cnt_q + CNT_W'(len)) : cnt_q;
        full  = cnt_d >= CNT_W'(PACK_W);
    end

    // Hold the accumulator and release the oldest PACK_W bits when full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            cnt_q      <= '0;
            word_valid <= 1'b0;
            word       <= '0;
        end else begin
            acc_q      <= acc_d;
            cnt_q      <= full ? (cnt_d - CNT_W'(PACK_W)) : cnt_d;
            word_valid <= full;
            if (full) begin
                word <= PACK_W'(acc_d >> (cnt_d - CNT_W'(PACK_W)));
            end
        end
    end

endmodule

// File: rtl/coef_skip_scanner.sv
// Zero-skipping 4x4 coefficient scanner. Loads a whole block in one cycle;
// empty blocks leave through a one-cycle codeword bypass into the bit packer,
// other blocks emit only their nonzero coefficients, highest index first,
// one per cycle. Assumes in_coefs is in zig-zag order and no output stall.
module coef_skip_scanner #(
    parameter int COEF_W = 16,
    parameter int NCOEF  = 16,
    parameter int PACK_W = 16,
    parameter int IDX_W  = $clog2(NCOEF),
    parameter int CNT_W  = $clog2(NCOEF + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [NCOEF*COEF_W-1:0] in_coefs,
    input  logic [1:0]              in_ctx,
    output logic                    out_valid,
    output logic [COEF_W-1:0]       out_coef,
    output logic [IDX_W-1:0]        out_idx,
    output logic [IDX_W-1:0]        out_run,
    output logic                    out_last,
    output logic [CNT_W-1:0]        out_total,
    output logic [1:0]              out_t1,
    output logic                    zb_valid,
    output logic [5:0]              zb_code,
    output logic [2:0]              zb_len,
    output logic                    pk_valid,
    output logic [PACK_W-1:0]       pk_word
);

    import csc_pkg::*;

    scan_state_e                    state_q;
    logic [NCOEF-1:0][COEF_W-1:0]   blk_q;
    logic [NCOEF-1:0]               mask_q, mask_rem;
    logic [IDX_W:0]                 prev_q;
    logic [CNT_W-1:0]               total_q;
    logic [1:0]                     t1_q;
    logic [1:0]                     ctx_q;

    logic [NCOEF-1:0]               ld_mask;
    logic [CNT_W-1:0]               ld_total;
    logic [1:0]                     ld_t1;
    logic [IDX_W-1:0]               cur_idx;

    // Load-time statistics on the incoming block.
    csc_load_stats #(
        .COEF_W (COEF_W),
        .NCOEF  (NCOEF),
        .CNT_W  (CNT_W)
    ) u_stats (
        .blk   (in_coefs),
        .mask  (ld_mask),
        .total (ld_total),
        .t1    (ld_t1)
    );

    // Next nonzero position from the remaining mask.
    csc_prio_enc #(
        .N     (NCOEF),
        .IDX_W (IDX_W)
    ) u_prio (
        .req (mask_q),
        .idx (cur_idx)
    );

    // Mask after the current position is consumed.
    always_comb begin
        mask_rem = mask_q & ~(NCOEF'(1) << cur_idx);
    end

    // Control and block state: load, bypass, scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            blk_q   <= '0;
            mask_q  <= '0;
            prev_q  <= (IDX_W+1)'(NCOEF);
            total_q <= '0;
            t1_q    <= '0;
            ctx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        blk_q   <= in_coefs;
                        mask_q  <= ld_mask;
                        prev_q  <= (IDX_W+1)'(NCOEF);
                        total_q <= ld_total;
                        t1_q    <= ld_t1;
                        ctx_q   <= in_ctx;
                        state_q <= (|ld_mask) ? ST_SCAN : ST_ZERO;
                    end
                end
                ST_ZERO: begin
                    state_q <= ST_IDLE;
                end
                ST_SCAN: begin
                    mask_q <= mask_rem;
                    prev_q <= {1'b0, cur_idx};
                    if (mask_rem == '0) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output view of the current scan step and the bypass codeword.
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_SCAN);
        out_idx   = cur_idx;
        out_coef  = blk_q[cur_idx];
        out_run   = IDX_W'(prev_q - {1'b0, cur_idx} - (IDX_W+1)'(1));
        out_last  = (state_q == ST_SCAN) && (mask_rem == '0);
        out_total = total_q;
        out_t1    = t1_q;
        zb_valid  = (state_q == ST_ZERO);
        zb_code   = zb_code_f(ctx_q);
        zb_len    = zb_len_f(ctx_q);
    end

    // Packer for the bypass codewords.
    csc_bit_packer #(
        .PACK_W (PACK_W),
        .CODE_W (ZB_CODE_W),
        .LEN_W  (ZB_LEN_W)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (zb_valid),
        .code       (zb_code),
        .len        (zb_len),
        .word_valid (pk_valid),
        .word       (pk_word)
    );

endmodule

// File: rtl/csc_checker.sv
// Temporal checks on the scanner ports; attached by bind below.
// Assumes the synchronous active-low reset of the scanner.
module csc_checker #(
    parameter int COEF_W = 16,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_last,
    input logic [IDX_W-1:0]  out_idx,
    input logic [COEF_W-1:0] out_coef,
    input logic [CNT_W-1:0]  out_total,
    input logic              zb_valid,
    input logic              pk_valid
);

    AST_ZB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        zb_valid |=> !zb_valid);                                       // R2
    AST_PATHS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(zb_valid && out_valid));                                     // R3
    AST_IDX_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && (out_idx < $past(out_idx)))); // R3
    AST_COEF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_coef != '0));                               // R4
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> (!out_valid && in_ready));         // R6
    AST_TOTAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> $stable(out_total));              // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || zb_valid) |-> !in_ready);                        // R9
    AST_PK_FOLLOWS_ZB: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |-> $past(zb_valid));                                 // R10

endmodule

bind coef_skip_scanner csc_checker #(
    .COEF_W (COEF_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
) u_csc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_idx   (out_idx),
    .out_coef  (out_coef),
    .out_total (out_total),
    .zb_valid  (zb_valid),
    .pk_valid  (pk_valid)
);

// File: tb/coef_skip_scanner_bench.sv
// Bench for the coefficient scanner: directed corners plus seeded random blocks.
module coef_skip_scanner_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] in_coefs = '0;
    logic [1:0]   in_ctx = '0;
    logic         out_valid;
    logic [15:0]  out_coef;
    logic [3:0]   out_idx;
    logic [3:0]   out_run;
    logic         out_last;
    logic [4:0]   out_total;
    logic [1:0]   out_t1;
    logic         zb_valid;
    logic [5:0]   zb_code;
    logic [2:0]   zb_len;
    logic         pk_valid;
    logic [15:0]  pk_word;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] cur [16];
    logic [1:0]  cur_ctx;
    bit          pq [$];
    bit          exp_pk = 1'b0;
    logic [15:0] exp_word = '0;

    always #5 clk = ~clk;

    coef_skip_scanner u_coef_skip_scanner (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_coefs(in_coefs), .in_ctx(in_ctx), .out_valid(out_valid),
        .out_coef(out_coef), .out_idx(out_idx), .out_run(out_run),
        .out_last(out_last), .out_total(out_total), .out_t1(out_t1),
        .zb_valid(zb_valid), .zb_code(zb_code), .zb_len(zb_len),
        .pk_valid(pk_valid), .pk_word(pk_word)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int exp_total();
        int n = 0;
        for (int i = 0; i < 16; i++) if (cur[i] != 0) n++;
        return n;
    endfunction

    function automatic int exp_t1();
        int n = 0;
        for (int i = 15; i >= 0; i--) begin
            if (cur[i] != 0) begin
                if ((cur[i] == 16'h0001 || cur[i] == 16'hFFFF) && n < 3) n++;
                else break;
            end
        end
        return n;
    endfunction

    function automatic logic [8:0] exp_zb(input logic [1:0] c);
        case (c)
            2'd0:    return {3'd1, 6'b000001};
            2'd1:    return {3'd2, 6'b000011};
            2'd2:    return {3'd4, 6'b001111};
            default: return {3'd6, 6'b000011};
        endcase
    endfunction

    task automatic junk_drive();
        in_valid = 1'b1;
        for (int i = 0; i < 16; i++) in_coefs[i*16 +: 16] = 16'($urandom);
        in_ctx = 2'($urandom);
    endtask

    // Offer cur/cur_ctx at a negedge with in_ready high and check the whole block.
    task automatic run_block();
        int tot = exp_total();
        int t1  = exp_t1();
        for (int i = 0; i < 16; i++) in_coefs[i*16 +: 16] = cur[i];
        in_ctx   = cur_ctx;
        in_valid = 1'b1;
        @(posedge clk);
        if (tot == 0) begin
            logic [8:0] z = exp_zb(cur_ctx);
            @(negedge clk);
            chk(zb_valid && !out_valid, "R2 zero block bypass", {zb_valid, out_valid}, 2'b10);
            chk({zb_len, zb_code} == z, "R2 zero block codeword", {zb_len, zb_code}, z);
            chk(!in_ready && !pk_valid, "R9 busy during bypass", {in_ready, pk_valid}, 0);
            for (int b = int'(z[8:6]) - 1; b >= 0; b--) pq.push_back(z[b]);
            if (pq.size() >= 16) begin
                exp_pk = 1'b1;
                for (int b = 15; b >= 0; b--) exp_word[b] = pq.pop_front();
            end
            junk_drive();
            @(negedge clk);
            chk(in_ready && !zb_valid, "R9 ready after bypass", {in_ready, zb_valid}, 2'b10);
            chk(pk_valid == exp_pk, "R10 packer valid", pk_valid, exp_pk);
            if (exp_pk) chk(pk_word == exp_word, "R10 packer word", pk_word, exp_word);
            exp_pk   = 1'b0;
            in_valid = 1'b0;
        end else begin
            int prev = 16;
            int left = tot;
            for (int i = 15; i >= 0; i--) begin
                if (cur[i] != 0) begin
                    left--;
                    @(negedge clk);
                    chk(out_valid && !zb_valid && !pk_valid, "R3 one step per nonzero",
                        {out_valid, zb_valid, pk_valid}, 3'b100);
                    chk(out_idx == 4'(i), "R3 descending index", out_idx, i);
                    chk(out_coef == cur[i], "R4 coefficient value", out_coef, cur[i]);
                    chk(out_run == 4'(prev - 1 - i), "R5 zero run", out_run, prev - 1 - i);
                    chk(out_last == (left == 0), "R6 last flag", out_last, left == 0);
                    chk(out_total == 5'(tot), "R7 nonzero count", out_total, tot);
                    chk(out_t1 == 2'(t1), "R8 trailing ones", out_t1, t1);
                    chk(!in_ready, "R9 busy during scan", in_ready, 0);
                    prev = i;
                    junk_drive();
                end
            end
            @(negedge clk);
            chk(in_ready && !out_valid, "R9 ready after last", {in_ready, out_valid}, 2'b10);
            in_valid = 1'b0;
        end
    endtask

    task automatic clear_blk();
        for (int i = 0; i < 16; i++) cur[i] = '0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid && !zb_valid && !pk_valid, "R1 reset state",
            {in_ready, out_valid, zb_valid, pk_valid}, 4'b1000);

        // R2: empty block under each context.
        for (int c = 0; c < 4; c++) begin
            clear_blk(); cur_ctx = 2'(c); run_block();
        end
        // R3 R5: single nonzero at each end.
        clear_blk(); cur[15] = 16'd7;      cur_ctx = 0; run_block();
        clear_blk(); cur[0]  = 16'hFFF0;   cur_ctx = 1; run_block();
        // R3: fully dense.
        for (int i = 0; i < 16; i++) cur[i] = 16'(i + 2);
        run_block();
        // R8: unit tails stopped after 0..4 units.
        for (int k = 0; k <= 4; k++) begin
            clear_blk();
            for (int j = 0; j < k; j++) cur[14 - 2*j] = (j % 2) ? 16'hFFFF : 16'h0001;
            cur[3] = 16'd9;
            cur[1] = 16'h0001;
            run_block();
        end

        // Random blocks: empty, sparse, dense, unit-heavy.
        for (int n = 0; n < 400; n++) begin
            int mode = int'($urandom % 4);
            cur_ctx = 2'($urandom);
            for (int i = 0; i < 16; i++) begin
                case (mode)
                    0: cur[i] = '0;
                    1: cur[i] = ($urandom % 8 == 0) ? 16'(int'($urandom % 7) - 3) : '0;
                    2: cur[i] = 16'($urandom);
                    default: begin
                        case ($urandom % 4)
                            0: cur[i] = 16'h0001;
                            1: cur[i] = 16'hFFFF;
                            2: cur[i] = 16'd2;
                            default: cur[i] = '0;
                        endcase
                    end
                endcase
            end
            run_block();
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: run did not complete");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule